// File: doc/BRIEF.md
# Saturating Health Log Accumulator

This block keeps the live wear and fault statistics of a board. It holds one small pending count per error class, bumped by events from hardware or software, and a live count of powered seconds. Neither count ever wraps. A neighbour owns a persistent record in slow storage. When that record has to be refreshed, the neighbour presents the error counts and the hour total it last stored and raises a merge request. One cycle later the block returns the merged values. It also returns the offset of the highest record byte that really changed, so the neighbour knows how far to rewrite.

After a merge the neighbour streams the old record bytes back through the block, starting at offset 0. The block puts its merged values into the error and hour slots and skips the checksum slot. It returns the new checksum at the end of the stream. Only whole hours leave the live seconds count. The part-hour remainder stays behind for the next merge.

Record layout used throughout: checksum byte at offset 1, error counter i at offset 4+i, hour total little-endian at offsets 8 (low byte) and 9 (high byte).

Top module: `health_log_acc`

## Requirements
- R1: An event with `evt_valid` high adds `evt_amt` to pending counter `evt_idx`. Counter i sits at bits [8i+7:8i] of `pend_cnt`, and the result is clamped at 255.
- R2: `need_merge` is high exactly when some pending counter is nonzero or `live_secs` is at least 3600.
- R3: A `merge_req` in one cycle makes `merge_done` high in the next cycle only. For each counter, `new_err` is the stored count plus the pending count, clamped at 255, or the stored count unchanged when the pending count is 0. All pending counters read 0 in the next cycle.
- R4: When `live_secs` is above 3600 at a merge, it drops to its remainder modulo 3600. When it is 3600 or less, no hours are moved and it keeps its value.
- R5: `new_hours` is `stored_hours` plus floor(`live_secs`/3600), clamped at 0xFFFF, when `live_secs` is above 3600. Otherwise it equals `stored_hours`.
- R6: `high_water` is the highest record offset whose merged byte differs from the stored byte: 4+i for error counter i, 8 for the hour low byte, 9 for the hour high byte. It is 0 when no byte differs.
- R7: Each cycle with `tick_sec` high adds one to `live_secs`. A tick in a merge cycle is added after the whole hours are removed.
- R8: `sum_start` resets the byte offset to 0. Each `sum_valid` byte takes the next offset. Bytes at offsets 4..7 and 8..9 are replaced by the latest merged error and hour bytes (zero after reset), and the byte at offset 1 is left out. In the cycle after the byte flagged `sum_last`, `sum_done` pulses and `sum_value` holds the bitwise inverse of the 8-bit sum.
- R9: An event that arrives in the same cycle as a merge becomes the new pending value of its counter (clamped at 255) instead of being lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Error event strobe |
| evt_idx | input | 2 | Error class of the event |
| evt_amt | input | 8 | Amount to add |
| tick_sec | input | 1 | One-second pulse |
| merge_req | input | 1 | Merge request strobe |
| stored_err | input | 32 | Stored error counts, counter i in byte i |
| stored_hours | input | 16 | Stored hour total |
| sum_start | input | 1 | Begin a checksum stream |
| sum_valid | input | 1 | Record byte valid |
| sum_last | input | 1 | Marks the final record byte |
| sum_byte | input | 8 | Record byte |
| pend_cnt | output | 32 | Pending error counters |
| live_secs | output | 24 | Live active seconds |
| need_merge | output | 1 | A merge has work to do |
| new_err | output | 32 | Merged error counts |
| new_hours | output | 16 | Merged hour total |
| high_water | output | 8 | Highest changed record offset |
| merge_done | output | 1 | Merge results valid |
| sum_value | output | 8 | New record checksum |
| sum_done | output | 1 | Checksum valid |

## Verification
The hardest conditions to reach are the hour boundary cases. These are a live count of exactly 3600, which needs a merge but moves nothing, and a transfer of several hours that carries into the high hour byte or clamps at 0xFFFF. The bench reaches them with long directed tick bursts of exact length, combined with chosen stored hour values such as 0x00FE and 0xFFFE. Random phases mix events, ticks and merges, including events and ticks that land in the merge cycle itself.

// File: rtl/hl_pkg.sv
`timescale 1ns/1ps
package hl_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
    localparam byte_t BYTE_MAX = '1;

    function automatic byte_t sat_add(byte_t a, byte_t b);
        logic [BYTE_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[BYTE_W] ? BYTE_MAX : s[BYTE_W-1:0];
    endfunction

    typedef struct packed {
        byte_t acc;
        byte_t value;
        logic  done;
    } csum_state_t;
endpackage

// File: rtl/hl_pending.sv
`timescale 1ns/1ps
module hl_pending
    import hl_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int IDX_W   = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      evt_valid,
    input  logic [IDX_W-1:0]          evt_idx,
    input  byte_t                     evt_amt,
    input  logic                      clear,
    output logic [NUM_CNT*BYTE_W-1:0] pend
);
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        logic  hit;
        byte_t cnt;
        assign hit = evt_valid && (evt_idx == IDX_W'(g));
        always_ff @(posedge clk) begin
            if (rst)
                cnt <= '0;
            else if (clear)
                cnt <= hit ? evt_amt : '0;
            else if (hit)
                cnt <= sat_add(cnt, evt_amt);
        end
        assign pend[g*BYTE_W +: BYTE_W] = cnt;
    end
endmodule

// File: rtl/hl_seconds.sv
`timescale 1ns/1ps
module hl_seconds #(
    parameter int SEC_W        = 24,
    parameter int SEC_PER_HOUR = 3600
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             merge,
    output logic [SEC_W-1:0] secs,
    output logic [SEC_W-1:0] whole_hours,
    output logic             at_hour
);
    localparam logic [SEC_W-1:0] SPH     = SEC_W'(SEC_PER_HOUR);
    localparam logic [SEC_W-1:0] SEC_MAX = '1;

    logic             over_hour;
    logic [SEC_W-1:0] base;
    logic [SEC_W-1:0] nxt;

    assign over_hour   = secs > SPH;
    assign at_hour     = secs >= SPH;
    assign whole_hours = over_hour ? secs / SPH : '0;

    always_comb begin
        base = (merge && over_hour) ? secs % SPH : secs;
        nxt  = (tick && base != SEC_MAX) ? base + 1'b1 : base;
    end

    always_ff @(posedge clk) begin
        if (rst)
            secs <= '0;
        else
            secs <= nxt;
    end
endmodule

// File: rtl/hl_merge.sv
`timescale 1ns/1ps
module hl_merge
    import hl_pkg::*;
#(
    parameter int NUM_CNT    = 4,
    parameter int HOUR_BYTES = 2,
    parameter int SEC_W      = 24,
    parameter int ERR_BASE   = 4,
    parameter int HOUR_BASE  = 8,
    parameter int OFF_W      = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         merge,
    input  logic [NUM_CNT*BYTE_W-1:0]    pend,
    input  logic [NUM_CNT*BYTE_W-1:0]    stored_err,
    input  logic [HOUR_BYTES*BYTE_W-1:0] stored_hours,
    input  logic [SEC_W-1:0]             whole_hours,
    output logic [NUM_CNT*BYTE_W-1:0]    new_err,
    output logic [HOUR_BYTES*BYTE_W-1:0] new_hours,
    output logic [OFF_W-1:0]             high_water,
    output logic                         merge_done
);
    localparam int HOUR_W = HOUR_BYTES * BYTE_W;
    localparam int SUM_W  = ((SEC_W > HOUR_W) ? SEC_W : HOUR_W) + 1;
    localparam logic [HOUR_W-1:0] HOUR_MAX = '1;

    logic [NUM_CNT*BYTE_W-1:0] err_c;
    logic [NUM_CNT-1:0]        err_chg;
    logic [HOUR_BYTES-1:0]     hr_chg;
    logic [SUM_W-1:0]          wide;
    logic [HOUR_W-1:0]         hours_c;
    logic [OFF_W-1:0]          hw_c;

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_err
        byte_t s, p;
        assign s = stored_err[g*BYTE_W +: BYTE_W];
        assign p = pend[g*BYTE_W +: BYTE_W];
        assign err_c[g*BYTE_W +: BYTE_W] = (p != '0) ? sat_add(s, p) : s;
        assign err_chg[g] = err_c[g*BYTE_W +: BYTE_W] != s;
    end

    assign wide    = SUM_W'(stored_hours) + SUM_W'(whole_hours);
    assign hours_c = (wide > SUM_W'(HOUR_MAX)) ? HOUR_MAX : wide[HOUR_W-1:0];

    for (genvar h = 0; h < HOUR_BYTES; h++) begin : g_hr
        assign hr_chg[h] = hours_c[h*BYTE_W +: BYTE_W] != stored_hours[h*BYTE_W +: BYTE_W];
    end

    // later assignments win, so the highest offset is kept
    always_comb begin
        hw_c = '0;
        for (int i = 0; i < NUM_CNT; i++)
            if (err_chg[i]) hw_c = OFF_W'(ERR_BASE + i);
        for (int j = 0; j < HOUR_BYTES; j++)
            if (hr_chg[j]) hw_c = OFF_W'(HOUR_BASE + j);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            new_err    <= '0;
            new_hours  <= '0;
            high_water <= '0;
            merge_done <= 1'b0;
        end else begin
            merge_done <= merge;
            if (merge) begin
                new_err    <= err_c;
                new_hours  <= hours_c;
                high_water <= hw_c;
            end
        end
    end
endmodule

// File: rtl/hl_csum.sv
`timescale 1ns/1ps
module hl_csum
    import hl_pkg::*;
#(
    parameter int NUM_CNT    = 4,
    parameter int HOUR_BYTES = 2,
    parameter int ERR_BASE   = 4,
    parameter int HOUR_BASE  = 8,
    parameter int CSUM_OFF   = 1,
    parameter int OFF_W      = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic                         valid,
    input  logic                         last,
    input  byte_t                        byte_in,
    input  logic [NUM_CNT*BYTE_W-1:0]    new_err,
    input  logic [HOUR_BYTES*BYTE_W-1:0] new_hours,
    output byte_t                        sum_value,
    output logic                         sum_done
);
    csum_state_t     st;
    logic [OFF_W-1:0] off;
    byte_t           sub;
    byte_t           contrib;

    always_comb begin
        sub = byte_in;
        for (int i = 0; i < NUM_CNT; i++)
            if (off == OFF_W'(ERR_BASE + i)) sub = new_err[i*BYTE_W +: BYTE_W];
        for (int j = 0; j < HOUR_BYTES; j++)
            if (off == OFF_W'(HOUR_BASE + j)) sub = new_hours[j*BYTE_W +: BYTE_W];
        contrib = (off == OFF_W'(CSUM_OFF)) ? '0 : sub;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= '0;
            off <= '0;
        end else begin
            st.done <= 1'b0;
            if (start) begin
                st.acc <= '0;
                off    <= '0;
            end else if (valid) begin
                st.acc <= st.acc + contrib;
                off    <= off + 1'b1;
                if (last) begin
                    st.value <= ~(st.acc + contrib);
                    st.done  <= 1'b1;
                end
            end
        end
    end

    assign sum_value = st.value;
    assign sum_done  = st.done;
endmodule

// File: rtl/health_log_acc.sv
`timescale 1ns/1ps
module health_log_acc
    import hl_pkg::*;
#(
    parameter int NUM_CNT      = 4,
    parameter int SEC_W        = 24,
    parameter int SEC_PER_HOUR = 3600,
    parameter int HOUR_BYTES   = 2,
    parameter int ERR_BASE     = 4,
    parameter int HOUR_BASE    = 8,
    parameter int CSUM_OFF     = 1,
    parameter int OFF_W        = 8,
    localparam int IDX_W       = $clog2(NUM_CNT),
    localparam int HOUR_W      = HOUR_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  evt_valid,
    input  logic [IDX_W-1:0]      evt_idx,
    input  logic [7:0]            evt_amt,
    input  logic                  tick_sec,
    input  logic                  merge_req,
    input  logic [NUM_CNT*8-1:0]  stored_err,
    input  logic [HOUR_W-1:0]     stored_hours,
    input  logic                  sum_start,
    input  logic                  sum_valid,
    input  logic                  sum_last,
    input  logic [7:0]            sum_byte,
    output logic [NUM_CNT*8-1:0]  pend_cnt,
    output logic [SEC_W-1:0]      live_secs,
    output logic                  need_merge,
    output logic [NUM_CNT*8-1:0]  new_err,
    output logic [HOUR_W-1:0]     new_hours,
    output logic [OFF_W-1:0]      high_water,
    output logic                  merge_done,
    output logic [7:0]            sum_value,
    output logic                  sum_done
);
    logic [SEC_W-1:0] whole_hours;
    logic             at_hour;

    hl_pending #(.NUM_CNT(NUM_CNT), .IDX_W(IDX_W)) u_pend (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_idx(evt_idx),
        .evt_amt(evt_amt), .clear(merge_req), .pend(pend_cnt)
    );

    hl_seconds #(.SEC_W(SEC_W), .SEC_PER_HOUR(SEC_PER_HOUR)) u_secs (
        .clk(clk), .rst(rst), .tick(tick_sec), .merge(merge_req),
        .secs(live_secs), .whole_hours(whole_hours), .at_hour(at_hour)
    );

    hl_merge #(
        .NUM_CNT(NUM_CNT), .HOUR_BYTES(HOUR_BYTES), .SEC_W(SEC_W),
        .ERR_BASE(ERR_BASE), .HOUR_BASE(HOUR_BASE), .OFF_W(OFF_W)
    ) u_merge (
        .clk(clk), .rst(rst), .merge(merge_req), .pend(pend_cnt),
        .stored_err(stored_err), .stored_hours(stored_hours),
        .whole_hours(whole_hours), .new_err(new_err), .new_hours(new_hours),
        .high_water(high_water), .merge_done(merge_done)
    );

    hl_csum #(
        .NUM_CNT(NUM_CNT), .HOUR_BYTES(HOUR_BYTES), .ERR_BASE(ERR_BASE),
        .HOUR_BASE(HOUR_BASE), .CSUM_OFF(CSUM_OFF), .OFF_W(OFF_W)
    ) u_csum (
        .clk(clk), .rst(rst), .start(sum_start), .valid(sum_valid),
        .last(sum_last), .byte_in(sum_byte), .new_err(new_err),
        .new_hours(new_hours), .sum_value(sum_value), .sum_done(sum_done)
    );

    assign need_merge = (|pend_cnt) || at_hour;
endmodule

// File: rtl/hl_checker.sv
`timescale 1ns/1ps
module hl_checker #(
    parameter int NUM_CNT      = 4,
    parameter int SEC_W        = 24,
    parameter int SEC_PER_HOUR = 3600,
    parameter int HOUR_W       = 16,
    parameter int ERR_BASE     = 4,
    parameter int HOUR_BASE    = 8,
    parameter int HOUR_BYTES   = 2,
    parameter int OFF_W        = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 evt_valid,
    input logic [7:0]           evt_amt,
    input logic                 merge_req,
    input logic [HOUR_W-1:0]    stored_hours,
    input logic [NUM_CNT*8-1:0] pend_cnt,
    input logic [SEC_W-1:0]     live_secs,
    input logic                 need_merge,
    input logic [HOUR_W-1:0]    new_hours,
    input logic [OFF_W-1:0]     high_water,
    input logic                 merge_done
);
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_mono
        AST_NO_DECREASE: assert property (@(posedge clk) disable iff (rst)
            !$past(merge_req) |-> pend_cnt[g*8 +: 8] >= $past(pend_cnt[g*8 +: 8])); // R1
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !need_merge |-> (pend_cnt == '0) && (live_secs < SEC_W'(SEC_PER_HOUR))); // R2

    AST_MERGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(merge_req) && !$past(evt_valid) |-> pend_cnt == '0); // R3

    AST_SECS_REDUCED: assert property (@(posedge clk) disable iff (rst)
        merge_done && ($past(live_secs) > SEC_W'(SEC_PER_HOUR)) |-> live_secs <= SEC_W'(SEC_PER_HOUR)); // R4

    AST_HOURS_GROW: assert property (@(posedge clk) disable iff (rst)
        merge_done |-> new_hours >= $past(stored_hours)); // R5

    AST_HW_LEGAL: assert property (@(posedge clk) disable iff (rst)
        merge_done |-> (high_water == '0) ||
            ((high_water >= OFF_W'(ERR_BASE)) && (high_water < OFF_W'(HOUR_BASE + HOUR_BYTES)))); // R6

    AST_LATE_EVT_KEPT: assert property (@(posedge clk) disable iff (rst)
        $past(merge_req) && $past(evt_valid) && ($past(evt_amt) != 8'd0) |-> pend_cnt != '0); // R9
endmodule

bind health_log_acc hl_checker #(
    .NUM_CNT(NUM_CNT), .SEC_W(SEC_W), .SEC_PER_HOUR(SEC_PER_HOUR), .HOUR_W(HOUR_W),
    .ERR_BASE(ERR_BASE), .HOUR_BASE(HOUR_BASE), .HOUR_BYTES(HOUR_BYTES), .OFF_W(OFF_W)
) u_chk (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_amt(evt_amt),
    .merge_req(merge_req), .stored_hours(stored_hours), .pend_cnt(pend_cnt),
    .live_secs(live_secs), .need_merge(need_merge), .new_hours(new_hours),
    .high_water(high_water), .merge_done(merge_done)
);

// File: tb/health_log_acc_test.sv
`timescale 1ns/1ps
module health_log_acc_test;
    localparam int SPH = 3600;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_valid = 1'b0;
    logic [1:0]  evt_idx = '0;
    logic [7:0]  evt_amt = '0;
    logic        tick_sec = 1'b0;
    logic        merge_req = 1'b0;
    logic [31:0] stored_err = '0;
    logic [15:0] stored_hours = '0;
    logic        sum_start = 1'b0;
    logic        sum_valid = 1'b0;
    logic        sum_last = 1'b0;
    logic [7:0]  sum_byte = '0;
    logic [31:0] pend_cnt;
    logic [23:0] live_secs;
    logic        need_merge;
    logic [31:0] new_err;
    logic [15:0] new_hours;
    logic [7:0]  high_water;
    logic        merge_done;
    logic [7:0]  sum_value;
    logic        sum_done;

    health_log_acc uut (.*);

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int m_pend[4];
    int m_secs = 0;
    int m_ne[4];
    int m_nh = 0;
    int seed_val;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int sat(int v, int mx);
        return (v > mx) ? mx : v;
    endfunction

    task automatic check_state(string req);
        bit nm;
        nm = (m_secs >= SPH);
        for (int i = 0; i < 4; i++) begin
            chk(pend_cnt[i*8 +: 8] == m_pend[i][7:0], req, "pending", pend_cnt[i*8 +: 8], m_pend[i]);
            if (m_pend[i] != 0) nm = 1'b1;
        end
        chk(live_secs == m_secs[23:0], req, "live_secs", live_secs, m_secs);
        chk(need_merge == nm, req, "need_merge", need_merge, nm);
    endtask

    task automatic send_evt(int idx, int amt);
        evt_valid = 1'b1; evt_idx = idx[1:0]; evt_amt = amt[7:0];
        @(negedge clk);
        evt_valid = 1'b0;
        m_pend[idx] = sat(m_pend[idx] + amt, 255);
    endtask

    task automatic ticks(int n);
        tick_sec = 1'b1;
        repeat (n) @(negedge clk);
        tick_sec = 1'b0;
        m_secs += n;
    endtask

    task automatic do_merge(logic [31:0] serr, int sh, bit ev, int idx, int amt, bit tk);
        int ne[4];
        int hrs, nh, hw;
        hw = 0;
        for (int i = 0; i < 4; i++) begin
            ne[i] = (m_pend[i] != 0) ? sat(int'(serr[i*8 +: 8]) + m_pend[i], 255) : int'(serr[i*8 +: 8]);
            if (ne[i] != int'(serr[i*8 +: 8])) hw = 4 + i;
        end
        hrs = (m_secs > SPH) ? m_secs / SPH : 0;
        nh  = sat(sh + hrs, 65535);
        if (nh[7:0] != sh[7:0]) hw = 8;
        if (nh[15:8] != sh[15:8]) hw = 9;
        stored_err = serr; stored_hours = sh[15:0];
        merge_req = 1'b1; tick_sec = tk;
        evt_valid = ev; evt_idx = idx[1:0]; evt_amt = amt[7:0];
        @(negedge clk);
        merge_req = 1'b0; tick_sec = 1'b0; evt_valid = 1'b0;
        chk(merge_done == 1'b1, "R3", "merge_done", merge_done, 1);
        for (int i = 0; i < 4; i++)
            chk(new_err[i*8 +: 8] == ne[i][7:0], "R3", "new_err", new_err[i*8 +: 8], ne[i]);
        chk(new_hours == nh[15:0], "R5", "new_hours", new_hours, nh);
        chk(high_water == hw[7:0], "R6", "high_water", high_water, hw);
        for (int i = 0; i < 4; i++) begin
            m_pend[i] = 0;
            m_ne[i] = ne[i];
        end
        if (ev) m_pend[idx] = sat(amt, 255);
        m_nh = nh;
        if (m_secs > SPH) m_secs = m_secs % SPH;
        m_secs += int'(tk);
        check_state("R4");
        @(negedge clk);
        chk(merge_done == 1'b0, "R3", "merge_done pulse", merge_done, 0);
    endtask

    task automatic stream(int len);
        int acc, b, sb, expv;
        acc = 0;
        sum_start = 1'b1;
        @(negedge clk);
        sum_start = 1'b0;
        for (int n = 0; n < len; n++) begin
            b = int'($urandom_range(0, 255));
            sb = b;
            if (n >= 4 && n <= 7) sb = m_ne[n - 4];
            if (n == 8) sb = m_nh & 255;
            if (n == 9) sb = (m_nh >> 8) & 255;
            if (n != 1) acc += sb;
            sum_valid = 1'b1; sum_byte = b[7:0]; sum_last = (n == len - 1);
            @(negedge clk);
        end
        sum_valid = 1'b0; sum_last = 1'b0;
        expv = (~acc) & 255;
        chk(sum_done == 1'b1, "R8", "sum_done", sum_done, 1);
        chk(sum_value == expv[7:0], "R8", "sum_value", sum_value, expv);
        @(negedge clk);
        chk(sum_done == 1'b0, "R8", "sum_done pulse", sum_done, 0);
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        seed_val = $urandom(32'd20240611);
        for (int i = 0; i < 4; i++) begin m_pend[i] = 0; m_ne[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        check_state("R2");
        chk(merge_done == 1'b0 && high_water == 8'd0, "R6", "reset outputs", high_water, 0);
        chk(new_hours == 16'd0, "R5", "reset hours", new_hours, 0);
        stream(12); // R8 with zero substitution after reset

        // R1 saturation
        send_evt(2, 200); send_evt(2, 100);
        check_state("R1");
        send_evt(0, 1);
        check_state("R1");
        // R9: event in merge cycle kept; R6 highest error offset
        do_merge(32'h00_10_F0_05, 16'h0123, 1'b1, 3, 7, 1'b0);
        check_state("R9");
        stream(10);

        // R4 boundary: exactly one hour, no transfer
        do_merge(32'h0, 16'h0010, 1'b0, 0, 0, 1'b0);
        ticks(3600);
        check_state("R2");
        do_merge(32'h0, 16'h0010, 1'b0, 0, 0, 1'b0);
        // R5/R6: multi-hour carry into high byte
        ticks(7205);
        do_merge(32'h0, 16'h00FE, 1'b0, 0, 0, 1'b1);
        stream(16);
        // clamp near full
        ticks(3601);
        do_merge(32'h0, 16'hFFFE, 1'b0, 0, 0, 1'b0);
        // already full: no byte change, high water 0
        ticks(3700);
        do_merge(32'hFFFFFFFF, 16'hFFFF, 1'b0, 0, 0, 1'b0);
        // R7 tick during merge below one hour
        ticks(10);
        do_merge(32'h01020304, 16'h0000, 1'b1, 1, 255, 1'b1);

        // random phase
        for (int it = 0; it < 300; it++) begin
            int r;
            r = int'($urandom_range(0, 9));
            if (r < 5)
                send_evt(int'($urandom_range(0, 3)), int'($urandom_range(0, 255)));
            else if (r < 8)
                ticks(int'($urandom_range(1, 400)));
            else begin
                do_merge($urandom(), int'($urandom_range(0, 65535)), 1'($urandom_range(0, 1)),
                         int'($urandom_range(0, 3)), int'($urandom_range(0, 255)),
                         1'($urandom_range(0, 1)));
                stream(int'($urandom_range(2, 16)));
            end
            check_state("R7");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule